// File: doc/BRIEF.md
# Segmented Carry-Select Arithmetic Chain

This block is the arithmetic column of a ten-cell logic block. Each cell holds two one-bit adder positions, which gives a 20-bit chain. A position does not add raw inputs. It looks up two operand bits, each from its own 16-entry programmable mask, both indexed by the same four local input bits. The masks act as free pre-adder logic: the same column can add, subtract, compare or mix in any function of four inputs before the carry chain.

Inside a cell, carry moves through a two-bit carry-select pair. Both possible results are formed ahead of the incoming carry, which then only drives a selector. The active span can be trimmed in two ways:
- The chain can begin at the sixth cell. The lower positions then pass the incoming carry through unchanged and read zero.
- A half mode confines the chain to the lower five cells. The carry leaving the fifth cell becomes the block's carry output, ready for the lower half of the next block in the column.

The result and carry output are registered. The same register can act as an up/down counter over the active span. Control comes from a clock enable, a synchronous clear, a count enable and a direction input.

Top module: `seg_arith_chain`

## Requirements
- R1: After reset both `sum_q` and `cout_q` are 0.
- R2: Position p takes operand bit x from `mask_x[p*16 + idx]` and operand bit y from `mask_y[p*16 + idx]`. Here idx is `lut_in[p*4 +: 4]`, and input a (`lut_in[p*4]`) is the least significant index bit.
- R3: In add mode (`sub_en`=0, `cnt_en`=0), one clock after an enabled edge `sum_q` holds X+Y+`carry_in` over the active positions. X and Y are the operand bits of R2. `cout_q` holds the carry out of the topmost active position.
- R4: With `sub_en`=1 (and `cnt_en`=0) the y operand bits are inverted and the chain carry-in is forced to 1, so `carry_in` has no effect. The result is X-Y, and `cout_q`=1 means no borrow.
- R5: With `start_hi`=1, positions 0..9 read 0 in `sum_q`. The chain carry-in enters at position 10.
- R6: With `half_mode`=1, positions 10..19 read 0. `cout_q` is the carry out of position 9.
- R7: With both `start_hi` and `half_mode` set, no position is active. `sum_q` is 0 and `cout_q` equals the chain carry-in (`carry_in` or `sub_en`, or the count carry in counter mode).
- R8: While `clk_en`=0, `sum_q` and `cout_q` hold, whatever the other inputs do.
- R9: `sync_clr`=1 with `clk_en`=1 clears both outputs. With `clk_en`=0 the clear is ignored.
- R10: With `cnt_en`=1 and `cnt_down`=0, the active span of `sum_q` is incremented by one at its lowest active position. Inactive positions read 0, `cout_q`=1 on wrap, and masks, `carry_in` and `sub_en` are ignored.
- R11: With `cnt_en`=1 and `cnt_down`=1, the active span is decremented by one. `cout_q`=0 only when the span was all zero (borrow).
- R12: `sync_clr` takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lut_in | input | 80 | Four local lookup inputs per position |
| mask_x | input | 320 | 16-bit lookup mask for the x operand of each position |
| mask_y | input | 320 | 16-bit lookup mask for the y operand of each position |
| carry_in | input | 1 | Chain carry-in for add mode |
| sub_en | input | 1 | Subtract: invert y, force carry-in to 1 |
| start_hi | input | 1 | Begin the chain at the sixth cell |
| half_mode | input | 1 | Confine the chain to the lower five cells |
| clk_en | input | 1 | Register clock enable |
| sync_clr | input | 1 | Synchronous clear, qualified by clk_en |
| cnt_en | input | 1 | Counter operation on the result register |
| cnt_down | input | 1 | Count direction, 1 = down |
| sum_q | output | 20 | Registered sum |
| cout_q | output | 1 | Registered chain carry-out |

## Verification
Operands are first built from constant masks, all ones or all zeros, so that exact sums with full carry ripple, wrap to zero and borrow can be chosen. Single-entry masks paired with mirror-image index values then tell a correct index bit order from a reversed one. Random masks and inputs under every combination of chain start and half mode separate the right active span and carry entry point from an off-by-one cell boundary. Counter runs across the all-ones and all-zero boundaries, in both spans, tell increment from decrement and check the priority of clear and enable.

// File: rtl/seg_arith_pkg.sv
package seg_arith_pkg;
  localparam int LUT_K        = 4;
  localparam int LUT_ENTRIES  = 1 << LUT_K;
  localparam int POS_PER_CELL = 2;

  typedef struct packed {
    logic x;
    logic y;
  } operand_pair_t;
endpackage

// File: rtl/lut_cell.sv
module lut_cell #(
  parameter int K = 4
) (
  input  logic [(1<<K)-1:0] mask,
  input  logic [K-1:0]      sel,
  output logic              y
);
  assign y = mask[sel];
endmodule

// File: rtl/carry_sel_pair.sv
module carry_sel_pair #(
  parameter int W = 2
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] act,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);
  logic [1:0][W-1:0] s_alt;
  logic [1:0]        c_alt;

  always_comb begin
    for (int k = 0; k < 2; k++) begin
      logic c;
      c = k[0];
      for (int i = 0; i < W; i++) begin
        if (act[i]) begin
          s_alt[k][i] = x[i] ^ y[i] ^ c;
          c           = (x[i] & y[i]) | (c & (x[i] ^ y[i]));
        end else begin
          s_alt[k][i] = 1'b0;
        end
      end
      c_alt[k] = c;
    end
  end

  assign s    = cin ? s_alt[1] : s_alt[0];
  assign cout = cin ? c_alt[1] : c_alt[0];
endmodule

// File: rtl/seg_arith_chain.sv
module seg_arith_chain
  import seg_arith_pkg::*;
#(
  parameter int N_CELLS        = 10,
  parameter int ALT_START_CELL = 5,
  parameter int HALF_CELLS     = 5,
  localparam int NBIT     = N_CELLS * POS_PER_CELL,
  localparam int ALT_POS  = ALT_START_CELL * POS_PER_CELL,
  localparam int HALF_POS = HALF_CELLS * POS_PER_CELL
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NBIT*LUT_K-1:0]       lut_in,
  input  logic [NBIT*LUT_ENTRIES-1:0] mask_x,
  input  logic [NBIT*LUT_ENTRIES-1:0] mask_y,
  input  logic                        carry_in,
  input  logic                        sub_en,
  input  logic                        start_hi,
  input  logic                        half_mode,
  input  logic                        clk_en,
  input  logic                        sync_clr,
  input  logic                        cnt_en,
  input  logic                        cnt_down,
  output logic [NBIT-1:0]             sum_q,
  output logic                        cout_q
);
  operand_pair_t [NBIT-1:0] lut_op;
  logic [NBIT-1:0]          op_x, op_y, act, sum_d;
  logic [N_CELLS:0]         chain_c;

  // Pre-adder lookups, one pair per adder position
  for (genvar p = 0; p < NBIT; p++) begin : g_pos
    lut_cell #(.K(LUT_K)) u_lut_x (
      .mask (mask_x[p*LUT_ENTRIES +: LUT_ENTRIES]),
      .sel  (lut_in[p*LUT_K +: LUT_K]),
      .y    (lut_op[p].x)
    );
    lut_cell #(.K(LUT_K)) u_lut_y (
      .mask (mask_y[p*LUT_ENTRIES +: LUT_ENTRIES]),
      .sel  (lut_in[p*LUT_K +: LUT_K]),
      .y    (lut_op[p].y)
    );
    assign act[p] = (start_hi ? (p >= ALT_POS) : 1'b1) &&
                    (half_mode ? (p < HALF_POS) : 1'b1);
  end

  // Operand selection: counter feedback or lookup results
  always_comb begin
    for (int p = 0; p < NBIT; p++) begin
      if (cnt_en) begin
        op_x[p] = sum_q[p];
        op_y[p] = cnt_down;
      end else begin
        op_x[p] = lut_op[p].x;
        op_y[p] = lut_op[p].y ^ sub_en;
      end
    end
    chain_c[0] = cnt_en ? ~cnt_down : (sub_en | carry_in);
  end

  // Carry-select pairs, one per cell
  for (genvar j = 0; j < N_CELLS; j++) begin : g_cell
    carry_sel_pair #(.W(POS_PER_CELL)) u_pair (
      .x    (op_x[j*POS_PER_CELL +: POS_PER_CELL]),
      .y    (op_y[j*POS_PER_CELL +: POS_PER_CELL]),
      .act  (act[j*POS_PER_CELL +: POS_PER_CELL]),
      .cin  (chain_c[j]),
      .s    (sum_d[j*POS_PER_CELL +: POS_PER_CELL]),
      .cout (chain_c[j+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q  <= '0;
      cout_q <= 1'b0;
    end else if (clk_en) begin
      if (sync_clr) begin
        sum_q  <= '0;
        cout_q <= 1'b0;
      end else begin
        sum_q  <= sum_d;
        cout_q <= chain_c[N_CELLS];
      end
    end
  end
endmodule

// File: rtl/seg_arith_chain_chk.sv
module seg_arith_chain_chk #(
  parameter int NBIT     = 20,
  parameter int ALT_POS  = 10,
  parameter int HALF_POS = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            start_hi,
  input logic            half_mode,
  input logic            clk_en,
  input logic            sync_clr,
  input logic            cnt_en,
  input logic            cnt_down,
  input logic [NBIT-1:0] sum_q,
  input logic            cout_q
);
  localparam logic [NBIT-1:0] ONE = {{(NBIT-1){1'b0}}, 1'b1};

  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sum_q == '0 && !cout_q));

  assert_low_span_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (clk_en && start_hi) |=> (sum_q[ALT_POS-1:0] == '0));

  assert_high_span_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (clk_en && half_mode) |=> (sum_q[NBIT-1:HALF_POS] == '0));

  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> ($stable(sum_q) && $stable(cout_q)));

  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (clk_en && sync_clr) |=> (sum_q == '0 && !cout_q));

  assert_count_up_R10: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !sync_clr && cnt_en && !cnt_down && !start_hi && !half_mode)
      |=> (sum_q == $past(sum_q) + ONE));

  assert_count_down_R11: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !sync_clr && cnt_en && cnt_down && !start_hi && !half_mode)
      |=> (sum_q == $past(sum_q) - ONE));
endmodule

bind seg_arith_chain seg_arith_chain_chk #(
  .NBIT(NBIT), .ALT_POS(ALT_POS), .HALF_POS(HALF_POS)
) u_chk (
  .clk(clk), .rst(rst), .start_hi(start_hi), .half_mode(half_mode),
  .clk_en(clk_en), .sync_clr(sync_clr), .cnt_en(cnt_en), .cnt_down(cnt_down),
  .sum_q(sum_q), .cout_q(cout_q)
);

// File: tb/seg_arith_chain_tb.sv
module seg_arith_chain_tb;
  localparam int NBIT = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NBIT*4-1:0]  lut_in = '0;
  logic [NBIT*16-1:0] mask_x = '0, mask_y = '0;
  logic carry_in = 0, sub_en = 0, start_hi = 0, half_mode = 0;
  logic clk_en = 0, sync_clr = 0, cnt_en = 0, cnt_down = 0;
  logic [NBIT-1:0] sum_q;
  logic cout_q;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [NBIT-1:0] m_sum = '0;
  logic m_cout = 0;
  logic [NBIT-1:0] q_sum[$];
  logic q_cout[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  seg_arith_chain u_dut (.*);

  // Builds masks so that operand X/Y bit p is a constant
  task automatic set_xy(input logic [NBIT-1:0] x, input logic [NBIT-1:0] y);
    for (int p = 0; p < NBIT; p++) begin
      mask_x[p*16 +: 16] = x[p] ? 16'hFFFF : 16'h0000;
      mask_y[p*16 +: 16] = y[p] ? 16'hFFFF : 16'h0000;
    end
  endtask

  task automatic randomize_ops();
    for (int p = 0; p < NBIT; p++) begin
      lut_in[p*4 +: 4]  = 4'($urandom);
      mask_x[p*16 +: 16] = 16'($urandom);
      mask_y[p*16 +: 16] = 16'($urandom);
    end
  endtask

  // Compute expected result from the requirements, push, advance one cycle
  task automatic cycle(input string tag);
    logic [NBIT-1:0] s;
    logic c, xb, yb;
    int lo, hi;
    lo = start_hi ? 10 : 0;
    hi = half_mode ? 10 : NBIT;
    if (clk_en) begin
      if (sync_clr) begin
        m_sum = '0; m_cout = 0;
      end else begin
        c = cnt_en ? ~cnt_down : (sub_en | carry_in);
        for (int p = 0; p < NBIT; p++) begin
          if (cnt_en) begin
            xb = m_sum[p]; yb = cnt_down;
          end else begin
            xb = mask_x[p*16 + int'(lut_in[p*4 +: 4])];
            yb = mask_y[p*16 + int'(lut_in[p*4 +: 4])] ^ sub_en;
          end
          if (p >= lo && p < hi) begin
            s[p] = xb ^ yb ^ c;
            c = (xb & yb) | (c & (xb ^ yb));
          end else begin
            s[p] = 1'b0;
          end
        end
        m_sum = s; m_cout = c;
      end
    end
    q_sum.push_back(m_sum);
    q_cout.push_back(m_cout);
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  // Monitor: compares after each edge that registered a driven item
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_sum.size() > 0) begin
        logic [NBIT-1:0] es;
        logic ec;
        string t;
        es = q_sum.pop_front(); ec = q_cout.pop_front(); t = q_tag.pop_front();
        checks++;
        if (sum_q !== es || cout_q !== ec) begin
          failures++;
          $display("FAIL %s: sum=%h cout=%b expected sum=%h cout=%b", t, sum_q, cout_q, es, ec);
        end
      end
    end
  end

  task automatic check_zero(input string tag);
    checks++;
    if (sum_q !== '0 || cout_q !== 1'b0) begin
      failures++;
      $display("FAIL %s: sum=%h cout=%b expected sum=00000 cout=0", tag, sum_q, cout_q);
    end
  endtask

  task automatic set_ctl(input logic ce, input logic clr, input logic cen, input logic cdn,
                         input logic shi, input logic hm, input logic sub, input logic cin);
    clk_en = ce; sync_clr = clr; cnt_en = cen; cnt_down = cdn;
    start_hi = shi; half_mode = hm; sub_en = sub; carry_in = cin;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check_zero("R1");

    // R3: plain add with constant operands
    set_ctl(1, 0, 0, 0, 0, 0, 0, 0);
    set_xy(20'h12345, 20'h0F0F0); cycle("R3");
    carry_in = 1; set_xy(20'hFFFFF, 20'h00000); cycle("R3");
    carry_in = 0; set_xy(20'hAAAAA, 20'h55555); cycle("R3");
    set_xy(20'h80000, 20'h80000); cycle("R3");

    // R2: index bit order of the lookups
    for (int p = 0; p < NBIT; p++) begin
      mask_x[p*16 +: 16] = 16'h0002; mask_y[p*16 +: 16] = 16'h0000; lut_in[p*4 +: 4] = 4'b0001;
    end
    cycle("R2");
    for (int p = 0; p < NBIT; p++) lut_in[p*4 +: 4] = 4'b1000;
    cycle("R2");
    for (int i = 0; i < 8; i++) begin randomize_ops(); carry_in = 1'($urandom); cycle("R2"); end

    // R4: subtract, carry_in ignored
    set_ctl(1, 0, 0, 0, 0, 0, 1, 0);
    set_xy(20'd5, 20'd7); cycle("R4");
    carry_in = 1; set_xy(20'd7, 20'd5); cycle("R4");
    set_xy(20'd9, 20'd9); cycle("R4");

    // R5 / R6 / R7: chain span selection
    for (int i = 0; i < 6; i++) begin
      set_ctl(1, 0, 0, 0, 1, 0, 1'($urandom), 1'($urandom)); randomize_ops(); cycle("R5");
    end
    set_ctl(1, 0, 0, 0, 1, 0, 0, 1); set_xy(20'hFFC00, 20'h0); cycle("R5");
    for (int i = 0; i < 6; i++) begin
      set_ctl(1, 0, 0, 0, 0, 1, 1'($urandom), 1'($urandom)); randomize_ops(); cycle("R6");
    end
    set_ctl(1, 0, 0, 0, 0, 1, 0, 1); set_xy(20'h003FF, 20'h0); cycle("R6");
    set_ctl(1, 0, 0, 0, 1, 1, 0, 1); randomize_ops(); cycle("R7");
    set_ctl(1, 0, 0, 0, 1, 1, 0, 0); cycle("R7");
    set_ctl(1, 0, 0, 0, 1, 1, 1, 0); cycle("R7");

    // R8: enable low holds
    set_ctl(1, 0, 0, 0, 0, 0, 0, 0); set_xy(20'h3C3C3, 20'h11111); cycle("R8");
    set_ctl(0, 0, 1, 1, 1, 0, 1, 1); randomize_ops(); cycle("R8");
    set_ctl(0, 1, 0, 0, 0, 1, 0, 0); cycle("R9");
    set_ctl(1, 1, 0, 0, 0, 0, 0, 1); randomize_ops(); cycle("R9");

    // R10 / R11 / R12: counter
    set_ctl(1, 0, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) cycle("R10");
    set_ctl(1, 0, 0, 0, 0, 0, 0, 0); set_xy(20'hFFFFE, 20'h0); cycle("R10");
    set_ctl(1, 0, 1, 0, 0, 0, 1, 1); randomize_ops(); cycle("R10"); cycle("R10");
    set_ctl(1, 0, 1, 1, 0, 0, 0, 0); cycle("R11"); cycle("R11");
    set_ctl(1, 1, 1, 0, 0, 0, 0, 0); cycle("R12");
    set_ctl(1, 0, 1, 1, 0, 0, 0, 0); cycle("R11");
    set_ctl(1, 0, 1, 0, 0, 1, 0, 0); cycle("R10"); cycle("R10");
    set_ctl(1, 0, 1, 1, 1, 0, 0, 0); cycle("R11"); cycle("R11");
    set_ctl(1, 0, 1, 0, 1, 1, 0, 0); cycle("R7");

    // Mixed random traffic
    for (int i = 0; i < 40; i++) begin
      set_ctl(($urandom % 4) != 0, ($urandom % 8) == 0, ($urandom % 3) == 0, 1'($urandom),
              ($urandom % 4) == 0, ($urandom % 4) == 0, 1'($urandom), 1'($urandom));
      randomize_ops();
      cycle("R3");
    end

    // R1: reset from a non-zero state
    set_ctl(1, 0, 0, 0, 0, 0, 0, 0); set_xy(20'hFFFFF, 20'hFFFFF); cycle("R3");
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    m_sum = '0; m_cout = 0;
    check_zero("R1");

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule